// File: doc/BRIEF.md
# Serial Command Frame Parser

This block takes bytes from a host serial link (one byte per `rx_valid` strobe, typically from a UART receiver) and executes register commands on an internal file of 32-bit registers. A frame opens with one ASCII lead character and is followed by a packed binary body whose multi-byte fields are little-endian. The block applies masked register writes, returns register values, and then sends an ASCII status line back to the host, one byte at a time, over a valid/ready output handshake.

A command frame gets only a status line back. A query frame gets the 32-bit result as four raw bytes first, and then the status line. A restart frame can clear the entire register file. If the sender stalls partway through a frame, the parser drops the partial frame after a configurable number of idle cycles. It then waits for a new lead character.

Top module: `cmdframe_parser`

## Requirements
- R1: After reset `tx_valid` is 0 and every register reads back as 0.
- R2: Lead 0x43 ('C') is followed by 12 body bytes: opcode (16 bits), address (16 bits), p1 (32 bits) and p2 (32 bits), each least significant byte first. The register index is the low ADDR_W bits of the address, and the upper address bits are ignored.
- R3: Opcode 0x0018 writes `(old & ~p2) | (p1 & p2)` to the indexed register and replies "OK\n" (bytes 0x4F 0x4B 0x0A).
- R4: Lead 0x51 ('Q') takes the same body. Its reply is four result bytes, least significant first, followed by the status line. The result is the indexed register for opcode 0x0010 and 0 for every other opcode.
- R5: Opcodes 0x0000 (no operation) and 0x0010 (read) reply OK and leave the registers unchanged. Any opcode other than 0x0000, 0x0010 or 0x0018 replies "ERR\n" (0x45 0x52 0x52 0x0A) and changes nothing.
- R6: A lead byte other than 0x43, 0x51 or 0x52 produces "ERR\n" at once. The next byte after that is treated as a new lead.
- R7: Lead 0x52 ('R') is followed by one argument byte. A value of 0x01 clears every register and replies OK. A value of 0x00 replies OK with the registers unchanged. Any other value replies ERR.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_valid` hold their values. Each accepted handshake advances the reply by exactly one byte.
- R9: Input bytes that arrive after a frame's last byte and before its reply has fully drained are dropped. They produce no reply and no register change.
- R10: Inside a frame, TIMEOUT_CYC consecutive cycles with no input byte discard the partial frame silently. A shorter gap keeps the frame intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Input byte strobe |
| rx_data | input | 8 | Input byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host accepts the reply byte |

## Verification
Several properties are checked on every cycle: a stalled reply byte stays stable, each decoded frame is a single-cycle pulse, no frame is decoded while a reply is in flight, a reply starts only right after a decoded frame, and no partial frame outlives the idle limit. The byte content of the replies can only be shown by the bench scenarios. This covers the masked-write arithmetic, query byte order, opcode and restart decoding, dropping of bytes during a reply, and recovery after a timeout. A behavioural model predicts each of these and compares the result byte by byte.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int WORD_W     = 32;
  localparam int BODY_BYTES = 12;

  localparam logic [7:0] LEAD_CMD = 8'h43;
  localparam logic [7:0] LEAD_QRY = 8'h51;
  localparam logic [7:0] LEAD_RST = 8'h52;

  localparam logic [15:0] OPC_NOP   = 16'h0000;
  localparam logic [15:0] OPC_RDMEM = 16'h0010;
  localparam logic [15:0] OPC_WRMEM = 16'h0018;

  localparam logic [7:0] CH_O  = 8'h4F;
  localparam logic [7:0] CH_K  = 8'h4B;
  localparam logic [7:0] CH_E  = 8'h45;
  localparam logic [7:0] CH_R  = 8'h52;
  localparam logic [7:0] CH_LF = 8'h0A;

  typedef enum logic [1:0] {K_CMD, K_QRY, K_RST, K_BAD} kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [15:0]        opc;
    logic [15:0]        addr;
    logic [WORD_W-1:0]  p1;
    logic [WORD_W-1:0]  p2;
  } frame_t;
endpackage

// File: rtl/cfp_framer.sv
module cfp_framer
  import cfp_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        hold,
  output logic        cmd_valid,
  output frame_t      cmd,
  output logic        in_frame
);
  localparam int GAP_W = $clog2(TIMEOUT_CYC + 1);
  localparam int CNT_W = $clog2(BODY_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_ARG} st_e;

  st_e                     st_q, st_d;
  kind_e                   kind_q, kind_d;
  logic [BODY_BYTES*8-1:0] body_q;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [GAP_W-1:0]        gap_q, gap_d;
  logic                    body_en, emit, take, gap_hit;

  assign take    = rx_valid && !hold && !cmd_valid;
  assign gap_hit = (gap_q == GAP_W'(TIMEOUT_CYC - 1));

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    gap_d   = '0;
    body_en = 1'b0;
    emit    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (take) begin
          cnt_d = '0;
          unique case (rx_data)
            LEAD_CMD: begin st_d = S_BODY; kind_d = K_CMD; end
            LEAD_QRY: begin st_d = S_BODY; kind_d = K_QRY; end
            LEAD_RST: begin st_d = S_ARG;  kind_d = K_RST; end
            default:  begin kind_d = K_BAD; emit = 1'b1; end
          endcase
        end
      end
      S_BODY, S_ARG: begin
        if (take) begin
          body_en = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (st_q == S_ARG || cnt_q == CNT_W'(BODY_BYTES - 1)) begin
            emit = 1'b1;
            st_d = S_IDLE;
          end
        end else if (gap_hit) begin
          st_d = S_IDLE;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      kind_q    <= K_BAD;
      cnt_q     <= '0;
      gap_q     <= '0;
      cmd_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      gap_q     <= gap_d;
      cmd_valid <= emit;
    end
  end

  // Bytes shift in from the top, so the first body byte ends in bits [7:0].
  // The single restart argument byte lands in the top byte (p2[31:24]).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       body_q <= '0;
    else if (body_en) body_q <= {rx_data, body_q[BODY_BYTES*8-1:8]};
  end

  assign cmd.kind = kind_q;
  assign cmd.opc  = body_q[15:0];
  assign cmd.addr = body_q[31:16];
  assign cmd.p1   = body_q[63:32];
  assign cmd.p2   = body_q[95:64];
  assign in_frame = (st_q != S_IDLE);
endmodule

// File: rtl/cfp_regfile.sv
module cfp_regfile #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] wr_mask,
  input  logic          clr_all,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rows [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en && (wr_addr == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clr_all) q <= '0;
      else if (hit)     q <= (q & ~wr_mask) | (wr_data & wr_mask);
    end
    assign rows[gi] = q;
  end

  assign rd_data = rows[rd_addr];
endmodule

// File: rtl/cfp_responder.sv
module cfp_responder
  import cfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              has_data,
  input  logic              is_err,
  input  logic [WORD_W-1:0] word,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready
);
  logic              busy_q, hasd_q, err_q;
  logic [2:0]        pos_q, last, dofs, spos;
  logic [WORD_W-1:0] word_q;

  assign dofs = hasd_q ? 3'd4 : 3'd0;
  assign last = dofs + (err_q ? 3'd3 : 3'd2);
  assign spos = pos_q - dofs;

  always_comb begin
    if (hasd_q && pos_q < 3'd4) begin
      unique case (pos_q[1:0])
        2'd0: tx_data = word_q[7:0];
        2'd1: tx_data = word_q[15:8];
        2'd2: tx_data = word_q[23:16];
        default: tx_data = word_q[31:24];
      endcase
    end else if (err_q) begin
      unique case (spos)
        3'd0:    tx_data = CH_E;
        3'd1,
        3'd2:    tx_data = CH_R;
        default: tx_data = CH_LF;
      endcase
    end else begin
      unique case (spos)
        3'd0:    tx_data = CH_O;
        3'd1:    tx_data = CH_K;
        default: tx_data = CH_LF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hasd_q <= 1'b0;
      err_q  <= 1'b0;
      pos_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      hasd_q <= has_data;
      err_q  <= is_err;
      pos_q  <= '0;
      word_q <= word;
    end else if (busy_q && tx_ready) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == last) busy_q <= 1'b0;
    end
  end

  assign tx_valid = busy_q;
endmodule

// File: rtl/cmdframe_parser.sv
module cmdframe_parser
  import cfp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready
);
  logic              rs_meta, rs_n;
  logic              cmd_valid, in_frame;
  frame_t            cmd;
  logic              wr_en, clr_all, ok;
  logic [WORD_W-1:0] rd_data, result;
  logic [7:0]        rst_arg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  cfp_framer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_framer (
    .clk(clk), .rst_n(rs_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .hold(tx_valid), .cmd_valid(cmd_valid), .cmd(cmd), .in_frame(in_frame)
  );

  cfp_regfile #(.DW(WORD_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rs_n), .wr_en(wr_en), .wr_addr(cmd.addr[ADDR_W-1:0]),
    .wr_data(cmd.p1), .wr_mask(cmd.p2), .clr_all(clr_all),
    .rd_addr(cmd.addr[ADDR_W-1:0]), .rd_data(rd_data)
  );

  assign rst_arg = cmd.p2[31:24];

  always_comb begin
    wr_en   = 1'b0;
    clr_all = 1'b0;
    ok      = 1'b0;
    result  = '0;
    if (cmd_valid) begin
      unique case (cmd.kind)
        K_BAD: ok = 1'b0;
        K_RST: begin
          ok      = (rst_arg == 8'h00) || (rst_arg == 8'h01);
          clr_all = (rst_arg == 8'h01);
        end
        default: begin
          unique case (cmd.opc)
            OPC_NOP:   ok = 1'b1;
            OPC_RDMEM: begin ok = 1'b1; result = rd_data; end
            OPC_WRMEM: begin ok = 1'b1; wr_en  = 1'b1;    end
            default:   ok = 1'b0;
          endcase
        end
      endcase
    end
  end

  cfp_responder u_resp (
    .clk(clk), .rst_n(rs_n), .load(cmd_valid),
    .has_data(cmd.kind == K_QRY), .is_err(!ok), .word(result),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int TIMEOUT_CYC = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       cmd_valid,
  input logic       in_frame
);
  localparam int GW = $clog2(TIMEOUT_CYC + 2);
  logic [GW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!in_frame || (rx_valid && !tx_valid && !cmd_valid)) idle_cnt <= '0;
    else idle_cnt <= idle_cnt + 1'b1;
  end

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r9_no_decode_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_valid);

  a_r2_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r4_reply_follows_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(cmd_valid));

  a_r10_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> (idle_cnt < GW'(TIMEOUT_CYC)));
endmodule

bind cmdframe_parser cfp_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .cmd_valid(cmd_valid),
  .in_frame(in_frame)
);

// File: tb/cmdframe_parser_test.sv
module cmdframe_parser_test;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_ready = 1'b1;
  logic       tx_valid;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rmode = 0;
  bit done = 0;

  logic [31:0] mregs [256];
  logic [7:0]  expq [$];
  string       tagq [$];
  logic        hold_chk = 1'b0;
  logic [7:0]  held;

  always #10 clk = ~clk;

  cmdframe_parser #(.ADDR_W(8), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor and reference comparison on every clock.
  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = (cyc % 3 == 0);
      default: tx_ready = 1'b0;
    endcase
    if (hold_chk) begin
      checks++;
      if (!tx_valid || tx_data !== held) begin
        errors++;
        $display("FAIL R8 stalled byte changed: valid=%0b data=%02h expected %02h",
                 tx_valid, tx_data, held);
      end
    end
    hold_chk = tx_valid && !tx_ready;
    held     = tx_data;
    if (tx_valid && tx_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected reply byte: actual=%02h expected none", tx_data);
      end else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (tx_data !== e) begin
          errors++;
          $display("FAIL %s reply byte: actual=%02h expected=%02h", t, tx_data, e);
        end
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  task automatic push(logic [7:0] b, string t);
    expq.push_back(b);
    tagq.push_back(t);
  endtask

  task automatic push_status(bit ok, string t);
    if (ok) begin
      push(8'h4F, t); push(8'h4B, t); push(8'h0A, t);
    end else begin
      push(8'h45, t); push(8'h52, t); push(8'h52, t); push(8'h0A, t);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] lead, logic [15:0] op, logic [15:0] addr,
                            logic [31:0] p1, logic [31:0] p2, int gap);
    logic [95:0] body;
    body = {p2, p1, addr, op};
    send_byte(lead);
    for (int i = 0; i < 12; i++) begin
      repeat (gap) @(negedge clk);
      send_byte(body[i*8 +: 8]);
    end
  endtask

  // Behavioural prediction of a C/Q frame.
  task automatic predict(logic [7:0] lead, logic [15:0] op, logic [15:0] addr,
                         logic [31:0] p1, logic [31:0] p2, string t);
    logic [31:0] res;
    bit ok;
    int idx;
    idx = int'(addr[7:0]);
    res = 32'h0;
    ok  = 1'b0;
    if (op == 16'h0000) ok = 1'b1;
    else if (op == 16'h0010) begin ok = 1'b1; res = mregs[idx]; end
    else if (op == 16'h0018) begin
      ok = 1'b1;
      mregs[idx] = (mregs[idx] & ~p2) | (p1 & p2);
    end
    if (lead == 8'h51)
      for (int i = 0; i < 4; i++) push(res[i*8 +: 8], t);
    push_status(ok, t);
  endtask

  task automatic run(logic [7:0] lead, logic [15:0] op, logic [15:0] addr,
                     logic [31:0] p1, logic [31:0] p2, string t);
    predict(lead, op, addr, p1, p2, t);
    send_frame(lead, op, addr, p1, p2, 0);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (expq.size() != 0 || tx_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic restart(logic [7:0] arg, string t);
    if (arg == 8'h01) for (int i = 0; i < 256; i++) mregs[i] = 32'h0;
    push_status(arg == 8'h00 || arg == 8'h01, t);
    send_byte(8'h52);
    send_byte(arg);
    wait_idle();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mregs[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset, unwritten register reads zero
    checks++;
    if (tx_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 tx_valid after reset: actual=%0b expected=0", tx_valid);
    end
    run(8'h51, 16'h0010, 16'h0055, 32'h0, 32'h0, "R1");
    wait_idle();

    // R2/R3/R4: full write then query read-back, byte order
    run(8'h43, 16'h0018, 16'h0012, 32'hDEADBEEF, 32'hFFFFFFFF, "R3");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R4");
    wait_idle();
    // R3: partial mask
    run(8'h43, 16'h0018, 16'h0012, 32'h12345678, 32'h0000FF00, "R3");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R3");
    wait_idle();
    // R2: upper address bits ignored
    run(8'h43, 16'h0718, 16'h0000, 32'h0, 32'h0, "R5");
    wait_idle();
    run(8'h43, 16'h0018, 16'hAB12, 32'hCAFE0000, 32'hFFFF0000, "R2");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R2");
    wait_idle();

    // R5: nop, read via C, unsupported opcodes; R4 zero result for non-read
    run(8'h43, 16'h0000, 16'h0012, 32'h5, 32'h5, "R5");
    wait_idle();
    run(8'h43, 16'h0010, 16'h0012, 32'h0, 32'h0, "R5");
    wait_idle();
    run(8'h43, 16'h0011, 16'h0012, 32'h0, 32'hFFFFFFFF, "R5");
    wait_idle();
    run(8'h51, 16'h0040, 16'h0012, 32'h0, 32'h0, "R5");
    wait_idle();
    run(8'h51, 16'h0018, 16'h0013, 32'h00000077, 32'h000000FF, "R4");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0013, 32'h0, 32'h0, "R5");
    wait_idle();

    // R6: bad lead, then a valid frame
    push_status(1'b0, "R6");
    send_byte(8'h58);
    wait_idle();
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R6");
    wait_idle();

    // R7: restart variants
    restart(8'h00, "R7");
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R7");
    wait_idle();
    restart(8'h05, "R7");
    restart(8'h01, "R7");
    run(8'h51, 16'h0010, 16'h0012, 32'h0, 32'h0, "R7");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0013, 32'h0, 32'h0, "R7");
    wait_idle();

    // R8: slow host
    rmode = 1;
    run(8'h43, 16'h0018, 16'h0040, 32'h89ABCDEF, 32'hFFFFFFFF, "R8");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0040, 32'h0, 32'h0, "R8");
    wait_idle();
    run(8'h43, 16'h0099, 16'h0040, 32'h0, 32'h0, "R8");
    wait_idle();

    // R9: bytes sent during a stalled reply are dropped
    rmode = 2;
    predict(8'h43, 16'h0018, 16'h0020, 32'h11111111, 32'hFFFFFFFF, "R9");
    send_frame(8'h43, 16'h0018, 16'h0020, 32'h11111111, 32'hFFFFFFFF, 0);
    while (!tx_valid) @(negedge clk);
    send_frame(8'h43, 16'h0018, 16'h0020, 32'h22222222, 32'hFFFFFFFF, 0);
    send_byte(8'h58);
    rmode = 0;
    wait_idle();
    run(8'h51, 16'h0010, 16'h0020, 32'h0, 32'h0, "R9");
    wait_idle();

    // R10: partial frame discarded after TO idle cycles
    send_byte(8'h43);
    for (int i = 0; i < 5; i++) send_byte(8'h18);
    repeat (TO) @(negedge clk);
    run(8'h43, 16'h0018, 16'h0030, 32'h000000A5, 32'hFFFFFFFF, "R10");
    wait_idle();
    run(8'h51, 16'h0010, 16'h0030, 32'h0, 32'h0, "R10");
    wait_idle();
    // R10: gaps just under the limit keep the frame
    predict(8'h43, 16'h0018, 16'h0031, 32'h0000005A, 32'hFFFFFFFF, "R10");
    send_frame(8'h43, 16'h0018, 16'h0031, 32'h0000005A, 32'hFFFFFFFF, TO - 1);
    wait_idle();
    run(8'h51, 16'h0010, 16'h0031, 32'h0, 32'h0, "R10");
    wait_idle();

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reply bytes: actual=%0d expected=0", expq.size());
    end
    summary();
  end
endmodule